// File: doc/BRIEF.md
# PCM Serial Bit-Clock and Frame-Sync Generator

This block is the timing master of a PCM audio port. It chooses one of two source clocks, both of which arrive as single-cycle enable pulses in the system clock domain. It divides the chosen source down to a serial bit clock, and a second counter groups the bit clocks into frames. The block drives the bit clock, a frame-sync pulse that lasts one bit period, the current bit index, and two single-cycle strobes. The data serializer launches a bit on one strobe and samples a bit on the other.

The bit clock rests high. Each bit starts with a falling edge, which is the launch point, and its rising edge halfway through the bit is the sample point. The frame-sync output is not inverted. Software sets the divider values, the source choice, a serial-clock enable and a continuous/gated mode bit. In continuous mode the clock runs whether or not any transfer is active. In gated mode the clock finishes the current frame and then parks once no transfer is active. A new divider value is picked up only at a frame boundary, so a frame is never shortened.

Top module: `pcm_clkgen`

## Requirements
- R1: Each half of a bit-clock period lasts exactly `cfg_bclk_div`+1 selected source ticks, so one bit lasts 2*(`cfg_bclk_div`+1) ticks.
- R2: A frame holds `cfg_sync_div`+1 bits. `bit_idx` counts 0 up to `cfg_sync_div` and then wraps to 0.
- R3: `fsync` goes high at the launch of bit 0 and goes low at the launch of bit 1, so it is high for exactly one bit period. When `cfg_sync_div` is 0, `fsync` stays high while the clock runs.
- R4: `cfg_src_bus`=1 times the bit clock from `bus_clk_en`; `cfg_src_bus`=0 times it from `aud_clk_en`.
- R5: `launch_stb` is a one-cycle pulse on the cycle `bclk` falls (`bclk` is 0 with it). `sample_stb` is a one-cycle pulse on the cycle `bclk` rises (`bclk` is 1 with it). The two are never high together.
- R6: While `cfg_sclk_en` is 0, from the cycle after it is sampled low, `bclk` is 1, `fsync` is 0 and no strobe is issued, whatever the other inputs are.
- R7: With `cfg_continuous`=1 and `cfg_sclk_en`=1, the clock runs even when `xfer_active` is 0. The first launch comes on the first selected tick after the clock is enabled.
- R8: With `cfg_continuous`=0, once `xfer_active` drops the clock completes the current frame. It then stops with `bclk`=1 and `fsync`=0 instead of launching a new frame.
- R9: A change to `cfg_bclk_div` or `cfg_sync_div` while the clock is running takes effect at the next frame boundary. The falling edge that ends the old frame is still timed with the old half-period.
- R10: After reset `bclk` is 1, `fsync` is 0, both strobes are 0 and `bit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_en | input | 1 | Tick of the bus/peripheral source clock |
| aud_clk_en | input | 1 | Tick of the audio mux source clock |
| cfg_src_bus | input | 1 | 1: time from bus tick, 0: from audio tick |
| cfg_bclk_div | input | DIV_W | Half bit-clock period minus one, in source ticks |
| cfg_sync_div | input | SYNC_W | Bits per frame minus one |
| cfg_sclk_en | input | 1 | Serial clock enable |
| cfg_continuous | input | 1 | 1: keep running while idle, 0: gated |
| xfer_active | input | 1 | A transmit or receive transfer is active |
| bclk | output | 1 | Serial bit clock, rests high |
| fsync | output | 1 | Frame sync, high during bit 0 |
| launch_stb | output | 1 | One-cycle strobe at the bclk falling edge |
| sample_stb | output | 1 | One-cycle strobe at the bclk rising edge |
| bit_idx | output | SYNC_W | Index of the current bit in the frame |

## Verification
The bench counts selected source ticks between successive strobes. A half-period counter that is off by one, or one that counts the source not selected, therefore shows up as a wrong gap on the very first bit. Divider values are changed in the middle of a running frame. A design that loads them at once truncates that frame and shows a short gap or a wrong bit index before the wrap. A one-bit frame checks that a sync counter compared against the wrong bound still holds `fsync` high throughout. The gated stop and the enable cut are both followed by idle windows in which any stray strobe, a low `bclk` or a lingering `fsync` is reported.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;
   // Bit-clock phase of the sequencer: parked, low half, high half
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } bclk_phase_e;
endpackage

// File: rtl/pcm_src_pick.sv
module pcm_src_pick (
   input  logic sel_bus,
   input  logic bus_tick,
   input  logic aud_tick,
   output logic tick
);
   always_comb begin
      tick = sel_bus ? bus_tick : aud_tick;
   end
endmodule

// File: rtl/pcm_half_div.sv
module pcm_half_div #(
   parameter int DIV_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic [DIV_W-1:0] div,
   output logic             edge_stb
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end   = (cnt_q == div);
   assign edge_stb = active && tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   // R1
   half_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt_q <= div));
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
   import pcm_clkgen_pkg::*;
#(
   parameter int DIV_W    = 9,
   parameter int SYNC_W   = 9,
   parameter int DIV_RST  = 0,
   parameter int SYNC_RST = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_en,
   input  logic              run_req,
   input  logic              tick,
   input  logic              edge_stb,
   input  logic [DIV_W-1:0]  new_div,
   input  logic [SYNC_W-1:0] new_sync,
   output logic [DIV_W-1:0]  act_div,
   output logic              active,
   output logic              bclk,
   output logic              fsync,
   output logic              launch_stb,
   output logic              sample_stb,
   output logic [SYNC_W-1:0] bit_idx
);
   bclk_phase_e       ph_q;
   logic [SYNC_W-1:0] idx_q;
   logic [SYNC_W-1:0] act_sync_q;
   logic [DIV_W-1:0]  act_div_q;
   logic              fs_q;
   logic              lch_q;
   logic              smp_q;
   logic              last_bit;

   assign last_bit = (idx_q == act_sync_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         idx_q      <= '0;
         act_sync_q <= SYNC_W'(SYNC_RST);
         act_div_q  <= DIV_W'(DIV_RST);
         fs_q       <= 1'b0;
         lch_q      <= 1'b0;
         smp_q      <= 1'b0;
      end else begin
         lch_q <= 1'b0;
         smp_q <= 1'b0;
         if (!sclk_en) begin
            ph_q       <= PH_IDLE;
            idx_q      <= '0;
            fs_q       <= 1'b0;
            act_sync_q <= new_sync;
            act_div_q  <= new_div;
         end else begin
            unique case (ph_q)
               PH_IDLE: begin
                  act_sync_q <= new_sync;
                  act_div_q  <= new_div;
                  if (tick && run_req) begin
                     ph_q  <= PH_LOW;
                     idx_q <= '0;
                     fs_q  <= 1'b1;
                     lch_q <= 1'b1;
                  end
               end
               PH_LOW: begin
                  if (edge_stb) begin
                     ph_q  <= PH_HIGH;
                     smp_q <= 1'b1;
                  end
               end
               PH_HIGH: begin
                  if (edge_stb) begin
                     if (!last_bit) begin
                        ph_q  <= PH_LOW;
                        idx_q <= idx_q + 1'b1;
                        fs_q  <= 1'b0;
                        lch_q <= 1'b1;
                     end else if (run_req) begin
                        ph_q       <= PH_LOW;
                        idx_q      <= '0;
                        fs_q       <= 1'b1;
                        lch_q      <= 1'b1;
                        act_sync_q <= new_sync;
                        act_div_q  <= new_div;
                     end else begin
                        ph_q  <= PH_IDLE;
                        idx_q <= '0;
                        fs_q  <= 1'b0;
                     end
                  end
               end
               default: ph_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign active     = (ph_q != PH_IDLE);
   assign bclk       = (ph_q != PH_LOW);
   assign fsync      = fs_q;
   assign launch_stb = lch_q;
   assign sample_stb = smp_q;
   assign bit_idx    = idx_q;
   assign act_div    = act_div_q;

   // R2
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (idx_q <= act_sync_q));

   // R9
   frame_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !$stable(act_sync_q)) |-> (lch_q && idx_q == '0));
endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
   parameter int DIV_W    = 9,
   parameter int SYNC_W   = 9,
   parameter int DIV_RST  = 0,
   parameter int SYNC_RST = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_clk_en,
   input  logic              aud_clk_en,
   input  logic              cfg_src_bus,
   input  logic [DIV_W-1:0]  cfg_bclk_div,
   input  logic [SYNC_W-1:0] cfg_sync_div,
   input  logic              cfg_sclk_en,
   input  logic              cfg_continuous,
   input  logic              xfer_active,
   output logic              bclk,
   output logic              fsync,
   output logic              launch_stb,
   output logic              sample_stb,
   output logic [SYNC_W-1:0] bit_idx
);
   localparam int SYNC_MAX = (1 << SYNC_W) - 1;
   localparam int DIV_MAX  = (1 << DIV_W) - 1;

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
         $error("pcm_clkgen: DIV_W out of range");
      end
      if (SYNC_W < 1 || SYNC_W > 16) begin : g_bad_sync_w
         $error("pcm_clkgen: SYNC_W out of range");
      end
      if (SYNC_RST < 0 || SYNC_RST > SYNC_MAX) begin : g_bad_sync_rst
         $error("pcm_clkgen: SYNC_RST does not fit SYNC_W");
      end
      if (DIV_RST < 0 || DIV_RST > DIV_MAX) begin : g_bad_div_rst
         $error("pcm_clkgen: DIV_RST does not fit DIV_W");
      end
   endgenerate

   logic             tick;
   logic             run_req;
   logic             active;
   logic             edge_stb;
   logic [DIV_W-1:0] act_div;

   assign run_req = cfg_sclk_en && (cfg_continuous || xfer_active);

   pcm_src_pick u_pick (
      .sel_bus  (cfg_src_bus),
      .bus_tick (bus_clk_en),
      .aud_tick (aud_clk_en),
      .tick     (tick)
   );

   pcm_half_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .tick     (tick),
      .div      (act_div),
      .edge_stb (edge_stb)
   );

   pcm_frame_seq #(
      .DIV_W    (DIV_W),
      .SYNC_W   (SYNC_W),
      .DIV_RST  (DIV_RST),
      .SYNC_RST (SYNC_RST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_en    (cfg_sclk_en),
      .run_req    (run_req),
      .tick       (tick),
      .edge_stb   (edge_stb),
      .new_div    (cfg_bclk_div),
      .new_sync   (cfg_sync_div),
      .act_div    (act_div),
      .active     (active),
      .bclk       (bclk),
      .fsync      (fsync),
      .launch_stb (launch_stb),
      .sample_stb (sample_stb),
      .bit_idx    (bit_idx)
   );

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch_stb && sample_stb));

   // R5
   launch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch_stb |-> !bclk);

   // R5
   sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> bclk);

   // R3
   fsync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> (launch_stb && bit_idx == '0));

   // R6
   sclk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sclk_en |=> (bclk && !fsync && !launch_stb && !sample_stb));
endmodule

// File: tb/sim_pcm_clkgen.sv
module sim_pcm_clkgen;
   localparam int DW = 9;
   localparam int SW = 9;

   typedef struct {
      bit smp;
      int idx;
      bit fs;
      int gap;
   } ev_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_clk_en = 1'b0;
   logic          aud_clk_en = 1'b0;
   logic          cfg_src_bus = 1'b1;
   logic [DW-1:0] cfg_bclk_div = '0;
   logic [SW-1:0] cfg_sync_div = '0;
   logic          cfg_sclk_en = 1'b0;
   logic          cfg_continuous = 1'b1;
   logic          xfer_active = 1'b0;
   logic          bclk, fsync, launch_stb, sample_stb;
   logic [SW-1:0] bit_idx;

   int   total = 0;
   int   bad = 0;
   int   gapcnt = 0;
   int   bus_ph = 0;
   int   aud_ph = 0;
   bit   done = 1'b0;
   ev_t  q[$];

   always #10 clk = ~clk;

   pcm_clkgen u0 (
      .clk(clk), .rst_n(rst_n), .bus_clk_en(bus_clk_en), .aud_clk_en(aud_clk_en),
      .cfg_src_bus(cfg_src_bus), .cfg_bclk_div(cfg_bclk_div), .cfg_sync_div(cfg_sync_div),
      .cfg_sclk_en(cfg_sclk_en), .cfg_continuous(cfg_continuous), .xfer_active(xfer_active),
      .bclk(bclk), .fsync(fsync), .launch_stb(launch_stb), .sample_stb(sample_stb),
      .bit_idx(bit_idx)
   );

   // source ticks: bus every 2nd cycle, audio every 3rd cycle
   always @(posedge clk) begin
      bus_ph <= (bus_ph == 1) ? 0 : bus_ph + 1;
      aud_ph <= (aud_ph == 2) ? 0 : aud_ph + 1;
      bus_clk_en <= (bus_ph == 1);
      aud_clk_en <= (aud_ph == 2);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pop expected strobe events and compare as they appear
   always @(negedge clk) begin
      if (rst_n && (launch_stb || sample_stb)) begin
         if (q.size() == 0) begin
            check(1'b0, "R6/R8 unexpected strobe", 1, 0);
         end else begin
            ev_t e;
            e = q.pop_front();
            check(sample_stb == e.smp, "R5 strobe kind", int'(sample_stb), int'(e.smp));
            check(bclk == e.smp, "R5 bclk level at strobe", int'(bclk), int'(e.smp));
            check(int'(bit_idx) == e.idx, "R2 bit index", int'(bit_idx), e.idx);
            check(fsync == e.fs, "R3 fsync", int'(fsync), int'(e.fs));
            if (e.gap != 0)
               check(gapcnt == e.gap, "R1/R4/R9 tick gap", gapcnt, e.gap);
         end
         gapcnt = 0;
      end
      if (cfg_src_bus ? bus_clk_en : aud_clk_en) gapcnt++;
   end

   task automatic push_frames(input int old_div, input int div, input int sync,
                              input int nfr, input bit first);
      for (int f = 0; f < nfr; f++) begin
         for (int b = 0; b <= sync; b++) begin
            ev_t e;
            e.smp = 1'b0; e.idx = b; e.fs = (b == 0);
            if (f == 0 && b == 0) e.gap = first ? 0 : old_div + 1;
            else                  e.gap = div + 1;
            q.push_back(e);
            e.smp = 1'b1; e.gap = div + 1;
            q.push_back(e);
         end
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #2;
   endtask

   task automatic drain_and_cut(input int left);
      while (q.size() > left) @(negedge clk);
      #2;
      cfg_sclk_en = 1'b0;
      step(2);
      // R6
      check(bclk == 1'b1, "R6 bclk parked after enable cut", int'(bclk), 1);
      check(fsync == 1'b0, "R6 fsync low after enable cut", int'(fsync), 0);
      q.delete();
      step(30);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      // R10 reset state
      check(bclk == 1'b1, "R10 bclk at reset", int'(bclk), 1);
      check(fsync == 1'b0, "R10 fsync at reset", int'(fsync), 0);
      check(!launch_stb && !sample_stb, "R10 strobes at reset",
            int'(launch_stb) + int'(sample_stb), 0);
      check(bit_idx == '0, "R10 bit index at reset", int'(bit_idx), 0);
      rst_n = 1'b1;
      step(2);

      // R7 continuous, no transfer, bus source, short frames
      cfg_src_bus = 1'b1; cfg_bclk_div = 9'd1; cfg_sync_div = 9'd3;
      cfg_continuous = 1'b1; xfer_active = 1'b0;
      push_frames(0, 1, 3, 4, 1'b1);
      cfg_sclk_en = 1'b1;
      drain_and_cut(2);

      // R4 audio source, other divider values
      cfg_src_bus = 1'b0; cfg_bclk_div = 9'd2; cfg_sync_div = 9'd5;
      push_frames(0, 2, 5, 2, 1'b1);
      cfg_sclk_en = 1'b1;
      drain_and_cut(2);

      // R9 change dividers mid-frame
      cfg_src_bus = 1'b1; cfg_bclk_div = 9'd0; cfg_sync_div = 9'd2;
      push_frames(0, 0, 2, 1, 1'b1);
      push_frames(0, 3, 4, 2, 1'b0);
      cfg_sclk_en = 1'b1;
      wait (launch_stb);
      step(1);
      cfg_bclk_div = 9'd3; cfg_sync_div = 9'd4;
      drain_and_cut(2);

      // R3 one-bit frame keeps fsync high
      cfg_bclk_div = 9'd1; cfg_sync_div = 9'd0;
      push_frames(0, 1, 0, 6, 1'b1);
      cfg_sclk_en = 1'b1;
      while (q.size() > 6) @(negedge clk);
      check(fsync == 1'b1, "R3 fsync held in one-bit frame", int'(fsync), 1);
      drain_and_cut(1);

      // R8 gated: one frame after transfer ends, then park
      cfg_continuous = 1'b0; xfer_active = 1'b1;
      cfg_bclk_div = 9'd1; cfg_sync_div = 9'd7;
      push_frames(0, 1, 7, 1, 1'b1);
      cfg_sclk_en = 1'b1;
      wait (launch_stb);
      step(1);
      xfer_active = 1'b0;
      while (q.size() > 0) @(negedge clk);
      step(60);
      check(q.size() == 0, "R8 gated frame completed", q.size(), 0);
      check(bclk == 1'b1, "R8 bclk parked after gated stop", int'(bclk), 1);
      check(fsync == 1'b0, "R8 fsync low after gated stop", int'(fsync), 0);

      // R6 enable clear with transfer requested: nothing produced
      cfg_sclk_en = 1'b0; cfg_continuous = 1'b1; xfer_active = 1'b1;
      step(50);
      check(bclk == 1'b1, "R6 bclk held while disabled", int'(bclk), 1);
      check(fsync == 1'b0, "R6 fsync held while disabled", int'(fsync), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule